// File: doc/BRIEF.md
# Pipelined One-Level 1-D Haar Transform Stage

This block performs a single decomposition level of the one-dimensional Haar wavelet on a vector of N signed integer samples. Consecutive samples are grouped into pairs (even index first). Each pair produces a low-band value, which is the halved sum, and a high-band value, which is the plain difference. Only adders and shifts are used, with no multipliers. The vector length N and the sample width are parameters. N is a power of two from 8 to 128.

Samples come one per cycle from an upstream fetch unit. That unit presents a sample with a request strobe only while this block holds its free line high. Result words leave on a data bus qualified by an enable strobe. All N/2 low-band words of a vector leave first, in pair order, and then all N/2 high-band words, in pair order. Each low-band word is sent as soon as its pair is complete. The high-band words are held in a small buffer and drained after the last low-band word. A done strobe marks the final word of each vector. A synchronous active-low reset discards any partly received vector.

Top module: `haar1d_stage`

## Requirements
- R1: The low-band word of pair p equals floor((x[2p] + x[2p+1]) / 2), computed on the sign-extended DW+1 bit sum with an arithmetic right shift, so that odd negative sums round toward negative infinity (for example, a sum of -3 gives -2).
- R2: The high-band word of pair p equals x[2p] - x[2p+1], computed at DW+1 bits with no scaling. The extreme inputs 127 - (-128) = 255 and -128 - 127 = -255 are represented exactly for DW = 8.
- R3: Output word k of a vector carries the low-band value of pair k for k < N/2, and the high-band value of pair k - N/2 for N/2 <= k < N.
- R4: in_free drops in the cycle after the last sample of a vector is accepted. It stays low while high-band words are drained, and it is high again in the cycle that shows the final word. The upstream raises in_req only while in_free is high.
- R5: Exactly N words with out_en high are produced per vector, and out_en is low in every other cycle.
- R6: out_last is high together with word N-1 of each vector and is low at all other times.
- R7: While rst_n is low at a clock edge, the next cycle shows in_free high, out_en low and out_last low. The next vector after reset is paired from sample 0 and drained from an empty buffer, even if the reset interrupted a vector.
- R8: A low-band word appears with out_en in the cycle right after the odd sample of its pair is accepted. Idle cycles with in_req low, including one between the two samples of a pair, do not change pairing or values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | 1 | Upstream sample valid, raised only while in_free is high |
| in_data | input | DW | Signed input sample |
| in_free | output | 1 | Block can accept a sample this cycle |
| out_en | output | 1 | out_data holds a result word |
| out_data | output | DW+1 | Signed result word (low band first, then high band) |
| out_last | output | 1 | Marks the final word of a vector |

## Verification
The checker assumes that the upstream never raises in_req while in_free is low, and it asserts this as an input rule. The bench driver waits for in_free before every sample and drops in_req otherwise, so the rule holds across back-to-back vectors, vectors with idle gaps, and reset applied partway through a vector or a drain. The checker counts accepted samples and emitted words modulo N on its own. This lets it place the free-line drop, the low-band latency and the done strobe in the right cycles without looking inside the datapath.

// File: rtl/haar_pkg.sv
// Package: shared types for the 1-D Haar stage.
// Assumes nothing beyond the two control phases used by the sequencer.
package haar_pkg;

    // Control phase: accepting samples, or draining buffered high-band words
    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } haar_phase_e;

endpackage

// File: rtl/haar_pair_unit.sv
// Module: haar_pair_unit
// Holds the even sample of a pair. When the odd sample arrives, it forms the
// halved sum and the unscaled difference at DW+1 bits.
// Assumes take/odd come from the sequencer and sample is signed two's complement.
module haar_pair_unit #(
    parameter int DW = 8,
    localparam int OW = DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic                 odd,
    input  logic signed [DW-1:0] sample,
    output logic                 pair_ok,
    output logic signed [OW-1:0] avg_w,
    output logic signed [OW-1:0] diff_w
);

    logic signed [DW-1:0] even_q;
    logic signed [OW-1:0] even_x;
    logic signed [OW-1:0] odd_x;
    logic signed [OW-1:0] sum_w;

    // Capture the first sample of each pair
    always_ff @(posedge clk) begin
        if (!rst_n)
            even_q <= '0;
        else if (take && !odd)
            even_q <= sample;
    end

    // Sign-extend operands, then add, shift and subtract
    always_comb begin
        even_x  = OW'(even_q);
        odd_x   = OW'(sample);
        sum_w   = even_x + odd_x;
        avg_w   = sum_w >>> 1;
        diff_w  = even_x - odd_x;
        pair_ok = take && odd;
    end

endmodule

// File: rtl/haar_diff_fifo.sv
// Module: haar_diff_fifo
// Small buffer that holds the high-band words of one vector until the drain.
// Assumes push and pop never exceed DEPTH outstanding entries (the sequencer
// guarantees this, because a vector fills the buffer before it drains).
module haar_diff_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Write storage; contents need no reset
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_data;
    end

    // Advance the pointers, wrapping at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Present the oldest entry
    assign pop_data = mem[rd_ptr];

endmodule

// File: rtl/haar_seq_ctrl.sv
// Module: haar_seq_ctrl
// Counts accepted samples and drained words, and switches between the fill
// and drain phases. Assumes N is a power of two of at least 8.
module haar_seq_ctrl
    import haar_pkg::*;
#(
    parameter int N  = 8,
    localparam int HALF = N / 2,
    localparam int SIW  = $clog2(N),
    localparam int DIW  = $clog2(HALF)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic drain,
    output logic odd,
    output logic pop,
    output logic pop_last
);

    haar_phase_e      phase_q;
    logic [SIW-1:0]   samp_idx;
    logic [DIW-1:0]   drain_idx;
    logic             last_samp;

    // Decode the sample and drain positions
    always_comb begin
        last_samp = (samp_idx == SIW'(N - 1));
        odd       = samp_idx[0];
        drain     = (phase_q == PH_DRAIN);
        pop       = drain;
        pop_last  = drain && (drain_idx == DIW'(HALF - 1));
    end

    // Count samples in the fill phase and words in the drain phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_FILL;
            samp_idx  <= '0;
            drain_idx <= '0;
        end else if (phase_q == PH_FILL) begin
            if (take) begin
                samp_idx <= last_samp ? '0 : samp_idx + 1'b1;
                if (last_samp)
                    phase_q <= PH_DRAIN;
            end
        end else begin
            if (pop_last) begin
                drain_idx <= '0;
                phase_q   <= PH_FILL;
            end else begin
                drain_idx <= drain_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/haar1d_stage.sv
// Module: haar1d_stage (top)
// One level of the 1-D Haar transform. Low-band words are emitted as each
// pair completes. High-band words are buffered and drained afterwards.
// Assumes in_req is raised only while in_free is high.
module haar1d_stage #(
    parameter int N  = 8,
    parameter int DW = 8,
    localparam int OW = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_req,
    input  logic [DW-1:0] in_data,
    output logic          in_free,
    output logic          out_en,
    output logic [OW-1:0] out_data,
    output logic          out_last
);

    logic          take;
    logic          drain;
    logic          odd;
    logic          pop;
    logic          pop_last;
    logic          pair_ok;
    logic [OW-1:0] avg_w;
    logic [OW-1:0] diff_w;
    logic [OW-1:0] fifo_q;

    assign in_free = !drain;
    assign take    = in_req && in_free;

    haar_seq_ctrl #(.N(N)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .drain    (drain),
        .odd      (odd),
        .pop      (pop),
        .pop_last (pop_last)
    );

    haar_pair_unit #(.DW(DW)) pair_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .odd     (odd),
        .sample  (in_data),
        .pair_ok (pair_ok),
        .avg_w   (avg_w),
        .diff_w  (diff_w)
    );

    haar_diff_fifo #(.W(OW), .DEPTH(N / 2)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (pair_ok),
        .push_data (diff_w),
        .pop       (pop),
        .pop_data  (fifo_q)
    );

    // Output register: a low-band word on pair completion, or a drained high-band word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en   <= 1'b0;
            out_data <= '0;
            out_last <= 1'b0;
        end else if (pair_ok) begin
            out_en   <= 1'b1;
            out_data <= avg_w;
            out_last <= 1'b0;
        end else if (pop) begin
            out_en   <= 1'b1;
            out_data <= fifo_q;
            out_last <= pop_last;
        end else begin
            out_en   <= 1'b0;
            out_last <= 1'b0;
        end
    end

endmodule

// File: rtl/haar1d_stage_chk.sv
// Module: haar1d_stage_chk
// Port-level checker for haar1d_stage. It keeps its own counts of accepted
// samples and emitted words, modulo N. Assumes N is a power of two.
module haar1d_stage_chk #(
    parameter int N = 8,
    localparam int CW = $clog2(N)
) (
    input logic clk,
    input logic rst_n,
    input logic in_req,
    input logic in_free,
    input logic out_en,
    input logic out_last
);

    logic [CW-1:0] acc_cnt;
    logic [CW-1:0] out_cnt;

    // Count accepted samples and emitted words independently of the design
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
            out_cnt <= '0;
        end else begin
            if (in_req && in_free)
                acc_cnt <= acc_cnt + 1'b1;
            if (out_en)
                out_cnt <= out_cnt + 1'b1;
        end
    end

    // R7: reset leaves the block idle and ready
    a_r7_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (in_free && !out_en && !out_last));

    // R4: input rule, no request while busy
    a_r4_req_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
        in_req |-> in_free);

    // R4: free drops after the last sample of a vector
    a_r4_free_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && in_free && acc_cnt == CW'(N - 1)) |=> !in_free);

    // R4: free stays low while high-band words other than the last are shown
    a_r4_busy_while_diffs: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && out_cnt >= CW'(N / 2) && out_cnt != CW'(N - 1)) |-> !in_free);

    // R6: done strobe only with a word
    a_r6_last_with_en: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_en);

    // R6: done strobe exactly on word N-1
    a_r6_last_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (out_last == (out_cnt == CW'(N - 1))));

    // R8: a low-band word follows an accepted sample by one cycle
    a_r8_avg_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && out_cnt < CW'(N / 2)) |-> $past(in_req && in_free));

endmodule

bind haar1d_stage haar1d_stage_chk #(.N(N)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .in_free  (in_free),
    .out_en   (out_en),
    .out_last (out_last)
);

// File: tb/haar1d_stage_tb_top.sv
// Testbench for haar1d_stage: a table of vectors walked by one loop, then
// directed reset cases. Outputs are captured at the falling edge.
module haar1d_stage_tb_top;

    localparam int N  = 8;
    localparam int DW = 8;
    localparam int OW = DW + 1;
    localparam int NV = 4;

    localparam logic signed [DW-1:0] VTAB [NV][N] = '{
        '{8'sd0,    8'sd1,    8'sd2,    8'sd3,    8'sd4,    8'sd5,    8'sd6,    8'sd7},
        '{8'sd127,  8'sd127,  -8'sd128, -8'sd128, 8'sd127,  -8'sd128, -8'sd128, 8'sd127},
        '{-8'sd1,   8'sd0,    -8'sd3,   8'sd0,    8'sd5,    -8'sd2,   -8'sd7,   -8'sd8},
        '{8'sd10,   -8'sd10,  8'sd33,   8'sd32,   -8'sd64,  8'sd65,   8'sd1,    8'sd1}
    };
    localparam bit GAPS [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_req = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_free;
    logic          out_en;
    logic [OW-1:0] out_data;
    logic          out_last;

    int checks = 0;
    int errors = 0;
    int cap_n = 0;
    int base = 0;
    bit done = 1'b0;
    logic signed [OW-1:0] cap_d [256];
    logic                 cap_l [256];

    always #4 clk = !clk;

    haar1d_stage #(.N(N), .DW(DW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_req   (in_req),
        .in_data  (in_data),
        .in_free  (in_free),
        .out_en   (out_en),
        .out_data (out_data),
        .out_last (out_last)
    );

    // Capture every result word at the falling edge
    always @(negedge clk) begin
        if (rst_n && out_en && cap_n < 256) begin
            cap_d[cap_n] = out_data;
            cap_l[cap_n] = out_last;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_word(input int v, input int idx);
        int p, a, b;
        p = (idx < N / 2) ? idx : idx - N / 2;
        a = VTAB[v][2 * p];
        b = VTAB[v][2 * p + 1];
        return (idx < N / 2) ? ((a + b) >>> 1) : (a - b);
    endfunction

    task automatic send_vec(input int v, input bit gaps);
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            #1;
            if (k == 2 && !gaps) begin
                // R8: first low-band word in the cycle after sample 1
                chk(out_en == 1'b1, "R8 en", int'(out_en), 1);
                chk($signed(out_data) == exp_word(v, 0), "R8 data",
                    int'($signed(out_data)), exp_word(v, 0));
            end
            while (!in_free) begin
                @(negedge clk);
                #1;
            end
            in_req  = 1'b1;
            in_data = VTAB[v][k];
            if (gaps && (k % 3 == 0) && k != N - 1) begin
                @(negedge clk);
                in_req = 1'b0;
            end
        end
        @(negedge clk);
        in_req = 1'b0;
        #1;
        chk(in_free == 1'b0, "R4 free drop", int'(in_free), 0);
    endtask

    task automatic collect_vec(input int v);
        while (cap_n < base + N) begin
            @(negedge clk);
            #1;
        end
        chk(in_free == 1'b1, "R4 free back", int'(in_free), 1);
        repeat (3) begin
            @(negedge clk);
            #1;
        end
        chk(cap_n == base + N, "R5 word count", cap_n - base, N);
        for (int i = 0; i < N; i++) begin
            // R1 low band, R2 high band, R3 order
            chk(int'(cap_d[base + i]) == exp_word(v, i),
                (i < N / 2) ? "R1 R3 avg" : "R2 R3 diff",
                int'(cap_d[base + i]), exp_word(v, i));
            chk(cap_l[base + i] == (i == N - 1), "R6 last",
                int'(cap_l[base + i]), int'(i == N - 1));
        end
        base = cap_n;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        in_req = 1'b0;
        rst_n  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(in_free == 1'b1, "R7 free", int'(in_free), 1);
        chk(out_en == 1'b0, "R7 en", int'(out_en), 0);
        chk(out_last == 1'b0, "R7 last", int'(out_last), 0);
        rst_n = 1'b1;
        base  = cap_n;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(in_free == 1'b1 && out_en == 1'b0, "R7 initial", int'(out_en), 0);
        rst_n = 1'b1;

        // Table walk: back-to-back vectors, some with idle gaps (R8)
        for (int v = 0; v < NV; v++) begin
            send_vec(v, GAPS[v]);
            collect_vec(v);
        end

        // R7: reset in the middle of a fill phase
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_req  = 1'b1;
            in_data = VTAB[3][k];
        end
        apply_reset();
        send_vec(2, 1'b0);
        collect_vec(2);

        // R7: reset in the middle of a drain phase
        send_vec(1, 1'b0);
        @(negedge clk);
        apply_reset();
        send_vec(3, 1'b0);
        collect_vec(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule